// File: doc/BRIEF.md
# Interrupt Controller Register Access Gate

This block is the register front end of a nested vectored interrupt controller. It decodes a 4 KB system control window and keeps the enable and pending bits and the priority of each external interrupt, up to `NUM_EXT` of them. It reads the active state from the core. From these it works out the current execution priority. Exception entry, preemption and timers belong to other blocks: this one only holds state, answers bus accesses and presents its vectors.

Every access carries a privilege flag. An unprivileged access fails with a bus error and changes nothing. The one exception is the software trigger word, which a user may write only when a bit in the configuration word permits it. Each request is taken in the cycle its valid is high. The response (valid, read data, error) comes one cycle later.

Top module: `intc_gate_top`

## Requirements
- R1: A request with `req_user`=1 to any word other than offset 0xF00 completes with `rsp_err`=1 and `rsp_rdata`=0, and changes no state (enable, pending, priority, configuration).
- R2: The configuration word at offset 0xD14 holds one bit, bit 1 (user trigger permit). It resets to 0, is written by a privileged full-word write, and reads back as that bit in position 1 with all other bits 0. An unprivileged access to 0xF00 is accepted only while the bit is 1; otherwise it returns `rsp_err`=1.
- R3: A write to 0xF00 takes `wdata[8:0]` as an external interrupt number n and sets the pending bit of n when n < `NUM_EXT`; otherwise it does nothing. Reads of 0xF00 return 0.
- R4: Offsets 0x100+4w set enable bits and 0x180+4w clear them. Bit b of word w is interrupt 32w+b, and a 0 bit in the data has no effect. Reads of either bank return the enable state, which also drives `en_o`.
- R5: Offsets 0x200+4w set pending bits and 0x280+4w clear them, with the same bit mapping. Reads of either bank return the pending state, which also drives `pend_o`.
- R6: Offsets 0x300+4w read the `act_i` input with the same bit mapping. Writes there are ignored and answer OK.
- R7: Offsets 0x400 to 0x5EF hold one priority byte per interrupt: byte 0x400+n belongs to interrupt n, and byte lane k of a word is `wdata[8k+7:8k]` under `req_strb[k]`. Only the top `PRIO_BITS` bits of each byte are kept, and the low bits read as 0.
- R8: `exec_prio` is a signed 10-bit value. It is -1 when `faultmask_i`=1. Otherwise it is 0 when `primask_i`=1. Otherwise, when `basepri_i` is nonzero, it is `basepri_i` with its low 8-`PRIO_BITS` bits cleared. Otherwise it is the smallest stored priority among the active interrupts, or 256 when none is active.
- R9: A privileged write with `req_strb` not equal to 4'hF outside the priority range has no effect and answers with `rsp_err`=0.
- R10: `req_ready` is always 1. Each request with `req_valid`=1 gets `rsp_valid`=1 in the next cycle. Unmapped offsets read 0 with no error. After reset all state is 0, `rsp_valid` is 0 and `exec_prio` is 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = unprivileged access |
| req_addr | input | 32 | Byte address; bits 11:0 decoded |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte lane strobes |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data (0 on writes and errors) |
| rsp_err | output | 1 | Bus error response |
| act_i | input | NUM_EXT | Active state per interrupt from the core |
| faultmask_i | input | 1 | Fault mask state |
| primask_i | input | 1 | Priority mask state |
| basepri_i | input | 8 | Base priority threshold |
| en_o | output | NUM_EXT | Enable vector |
| pend_o | output | NUM_EXT | Pending vector |
| exec_prio | output | 10 | Signed execution priority |

## Verification
The register map is driven with set and clear patterns that have mixed ones and zeros, so that a bank that wrote all bits, or wrote into the wrong bank, would read back differently. The same accesses are repeated with the user flag set, before and after the permit bit changes, to tell a gate that blocks too much apart from one that lets too much through. Priority bytes are written with sparse strobe patterns and all-ones data, which exposes lane swaps and stored low bits. The execution priority is then stepped through each mask level in turn with several active sets.

// File: rtl/intc_gate_pkg.sv
// Package: shared region codes and offsets for the interrupt register gate.
// Assumes a 4 KB window decoded from address bits 11:0.
package intc_gate_pkg;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_SETEN,
        RG_CLREN,
        RG_SETPD,
        RG_CLRPD,
        RG_ACT,
        RG_PRIO,
        RG_CFG,
        RG_TRIG
    } region_t;

    localparam logic [11:0] OFF_PRIO_LO = 12'h400;
    localparam logic [11:0] OFF_PRIO_HI = 12'h5EF;
    localparam logic [9:0]  WRD_CFG     = 10'h345;  // 0xD14 >> 2
    localparam logic [9:0]  WRD_TRIG    = 10'h3C0;  // 0xF00 >> 2

endpackage

// File: rtl/intc_gate_decode.sv
// Module: address decoder and privilege gate.
// Maps the 12-bit offset to a region and its word index, and decides
// whether the access may proceed given the privilege flag and permit bit.
// Purely combinational; assumes word-aligned offsets for word regions.
module intc_gate_decode
    import intc_gate_pkg::*;
(
    input  logic [11:0] off,
    input  logic        user,
    input  logic        usr_permit,
    output region_t     region,
    output logic [3:0]  bank_word,
    output logic [6:0]  prio_word,
    output logic        allowed
);
    logic [11:0] prio_rel;

    // Region selection from the offset.
    always_comb begin
        region = RG_NONE;
        unique casez (off[11:6])
            6'b0001_00: region = RG_SETEN;
            6'b0001_10: region = RG_CLREN;
            6'b0010_00: region = RG_SETPD;
            6'b0010_10: region = RG_CLRPD;
            6'b0011_00: region = RG_ACT;
            default:    region = RG_NONE;
        endcase
        if (off >= OFF_PRIO_LO && off <= OFF_PRIO_HI) region = RG_PRIO;
        if (off[11:2] == WRD_CFG)  region = RG_CFG;
        if (off[11:2] == WRD_TRIG) region = RG_TRIG;
    end

    // Word indices inside the banked and priority regions.
    always_comb begin
        prio_rel  = off - OFF_PRIO_LO;
        bank_word = off[5:2];
        prio_word = prio_rel[8:2];
    end

    // Privilege gate: user reaches only the trigger word, and only when permitted.
    always_comb begin
        allowed = !user || ((region == RG_TRIG) && usr_permit);
    end

    logic unused_prio;
    assign unused_prio = ^{prio_rel[11:9], prio_rel[1:0]};

endmodule

// File: rtl/intc_gate_irqstate.sv
// Module: enable and pending bit storage for NUM_EXT interrupts.
// Handles set/clear banks and the software trigger; produces 32-bit
// read words for enable, pending and the external active vector.
// Assumes at most one write strobe input is high per cycle.
module intc_gate_irqstate #(
    parameter int NUM_EXT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seten_we,
    input  logic               clren_we,
    input  logic               setpd_we,
    input  logic               clrpd_we,
    input  logic               trig_we,
    input  logic [8:0]         trig_idx,
    input  logic [3:0]         bank_word,
    input  logic [31:0]        wdata,
    input  logic [NUM_EXT-1:0] act_i,
    output logic [NUM_EXT-1:0] en_q,
    output logic [NUM_EXT-1:0] pd_q,
    output logic [31:0]        rd_en,
    output logic [31:0]        rd_pd,
    output logic [31:0]        rd_act
);
    // Enable and pending update, one request per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            pd_q <= '0;
        end else begin
            for (int i = 0; i < NUM_EXT; i++) begin
                if (int'(bank_word) == i / 32) begin
                    if (seten_we && wdata[i % 32]) en_q[i] <= 1'b1;
                    if (clren_we && wdata[i % 32]) en_q[i] <= 1'b0;
                    if (setpd_we && wdata[i % 32]) pd_q[i] <= 1'b1;
                    if (clrpd_we && wdata[i % 32]) pd_q[i] <= 1'b0;
                end
                if (trig_we && int'(trig_idx) == i) pd_q[i] <= 1'b1;
            end
        end
    end

    // Read words for the addressed bank.
    always_comb begin
        rd_en  = '0;
        rd_pd  = '0;
        rd_act = '0;
        for (int i = 0; i < NUM_EXT; i++) begin
            if (int'(bank_word) == i / 32) begin
                rd_en[i % 32]  = en_q[i];
                rd_pd[i % 32]  = pd_q[i];
                rd_act[i % 32] = act_i[i];
            end
        end
    end

    // Out-of-range trigger leaves pending untouched.
    assert_trig_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && int'(trig_idx) >= NUM_EXT && !setpd_we && !clrpd_we) |=> $stable(pd_q));

    // Clear bank bit 0 of word 0 drops interrupt 0 enable.
    assert_clr_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clren_we && !seten_we && bank_word == 4'd0 && wdata[0]) |=> !en_q[0]);

endmodule

// File: rtl/intc_gate_prio.sv
// Module: priority byte storage and active-priority finder.
// Keeps PRIO_BITS per interrupt (the top bits of each byte), serves the
// addressed priority word, and finds the smallest priority among active
// interrupts (256 when none). Assumes 1 <= PRIO_BITS <= 8.
module intc_gate_prio #(
    parameter int NUM_EXT   = 32,
    parameter int PRIO_BITS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [6:0]         prio_word,
    input  logic [3:0]         strb,
    input  logic [31:0]        wdata,
    input  logic [NUM_EXT-1:0] act_i,
    output logic [31:0]        rd_prio,
    output logic [8:0]         act_min
);
    localparam int SHIFT = 8 - PRIO_BITS;

    logic [PRIO_BITS-1:0] prio_q [NUM_EXT];

    // Byte-lane priority writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_EXT; i++) prio_q[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NUM_EXT; i++) begin
                if (int'(prio_word) == i / 4 && strb[i % 4])
                    prio_q[i] <= wdata[(i % 4) * 8 + 7 -: PRIO_BITS];
            end
        end
    end

    // Addressed priority word with low bits zero.
    always_comb begin
        rd_prio = '0;
        for (int i = 0; i < NUM_EXT; i++) begin
            if (int'(prio_word) == i / 4)
                rd_prio[(i % 4) * 8 +: 8] = 8'(prio_q[i]) << SHIFT;
        end
    end

    // Smallest priority among active interrupts.
    always_comb begin
        act_min = 9'd256;
        for (int i = 0; i < NUM_EXT; i++) begin
            if (act_i[i] && ({1'b0, 8'(prio_q[i]) << SHIFT} < act_min))
                act_min = {1'b0, 8'(prio_q[i]) << SHIFT};
        end
    end

endmodule

// File: rtl/intc_gate_exec.sv
// Module: execution priority selection.
// Fault mask beats priority mask, which beats a nonzero base priority,
// which beats the active-interrupt minimum. Output is signed 10-bit.
module intc_gate_exec #(
    parameter int PRIO_BITS = 3
) (
    input  logic              faultmask_i,
    input  logic              primask_i,
    input  logic [7:0]        basepri_i,
    input  logic [8:0]        act_min,
    output logic signed [9:0] exec_prio
);
    localparam logic [7:0] PMASK = 8'(8'hFF << (8 - PRIO_BITS));

    // Priority ladder of the mask sources.
    always_comb begin
        if (faultmask_i)            exec_prio = -10'sd1;
        else if (primask_i)         exec_prio = 10'sd0;
        else if (basepri_i != 8'd0) exec_prio = $signed({2'b00, basepri_i & PMASK});
        else                        exec_prio = $signed({1'b0, act_min});
    end

endmodule

// File: rtl/intc_gate_top.sv
// Module: interrupt controller register access gate, top level.
// Accepts one request per cycle (ready always high), applies the privilege
// gate, updates state at the clock edge and returns a registered response
// one cycle later. Full-word writes are required outside the priority range.
module intc_gate_top
    import intc_gate_pkg::*;
#(
    parameter int NUM_EXT   = 32,
    parameter int PRIO_BITS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_user,
    input  logic [31:0]        req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [3:0]         req_strb,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               rsp_err,
    input  logic [NUM_EXT-1:0] act_i,
    input  logic               faultmask_i,
    input  logic               primask_i,
    input  logic [7:0]         basepri_i,
    output logic [NUM_EXT-1:0] en_o,
    output logic [NUM_EXT-1:0] pend_o,
    output logic signed [9:0]  exec_prio
);
    localparam logic [7:0]  LOWB  = 8'(~(8'hFF << (8 - PRIO_BITS)));
    localparam logic [31:0] LOW32 = {4{LOWB}};

    region_t     region;
    logic [3:0]  bank_word;
    logic [6:0]  prio_word;
    logic        allowed;
    logic        usr_permit_q;
    logic        acc, wr, word_wr;
    logic [31:0] rd_en, rd_pd, rd_act, rd_prio, rd_mux;
    logic [8:0]  act_min;

    assign req_ready = 1'b1;

    intc_gate_decode u_dec (
        .off        (req_addr[11:0]),
        .user       (req_user),
        .usr_permit (usr_permit_q),
        .region     (region),
        .bank_word  (bank_word),
        .prio_word  (prio_word),
        .allowed    (allowed)
    );

    // Qualified write strobes.
    always_comb begin
        acc     = req_valid && allowed;
        wr      = acc && req_write;
        word_wr = wr && (req_strb == 4'hF);
    end

    intc_gate_irqstate #(.NUM_EXT(NUM_EXT)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .seten_we  (word_wr && region == RG_SETEN),
        .clren_we  (word_wr && region == RG_CLREN),
        .setpd_we  (word_wr && region == RG_SETPD),
        .clrpd_we  (word_wr && region == RG_CLRPD),
        .trig_we   (word_wr && region == RG_TRIG),
        .trig_idx  (req_wdata[8:0]),
        .bank_word (bank_word),
        .wdata     (req_wdata),
        .act_i     (act_i),
        .en_q      (en_o),
        .pd_q      (pend_o),
        .rd_en     (rd_en),
        .rd_pd     (rd_pd),
        .rd_act    (rd_act)
    );

    intc_gate_prio #(.NUM_EXT(NUM_EXT), .PRIO_BITS(PRIO_BITS)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr && region == RG_PRIO),
        .prio_word (prio_word),
        .strb      (req_strb),
        .wdata     (req_wdata),
        .act_i     (act_i),
        .rd_prio   (rd_prio),
        .act_min   (act_min)
    );

    intc_gate_exec #(.PRIO_BITS(PRIO_BITS)) u_exec (
        .faultmask_i (faultmask_i),
        .primask_i   (primask_i),
        .basepri_i   (basepri_i),
        .act_min     (act_min),
        .exec_prio   (exec_prio)
    );

    // Configuration word: user trigger permit bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        usr_permit_q <= 1'b0;
        else if (word_wr && region == RG_CFG) usr_permit_q <= req_wdata[1];
    end

    // Read data selection by region.
    always_comb begin
        unique case (region)
            RG_SETEN, RG_CLREN: rd_mux = rd_en;
            RG_SETPD, RG_CLRPD: rd_mux = rd_pd;
            RG_ACT:             rd_mux = rd_act;
            RG_PRIO:            rd_mux = rd_prio;
            RG_CFG:             rd_mux = {30'd0, usr_permit_q, 1'b0};
            default:            rd_mux = '0;
        endcase
    end

    // Registered one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !allowed;
            rsp_rdata <= (acc && !req_write) ? rd_mux : '0;
        end
    end

    logic unused_addr;
    assign unused_addr = ^req_addr[31:12];

    assert_user_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && req_addr[11:2] != WRD_TRIG) |=> (rsp_err && rsp_rdata == 32'd0));

    assert_user_noeff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && req_addr[11:2] != WRD_TRIG) |=> ($stable(en_o) && $stable(pend_o)));

    assert_ign_nonword_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_user && req_strb != 4'hF && req_addr[11:6] == 6'h04)
        |=> ($stable(en_o) && !rsp_err));

    assert_prio_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_user && req_addr[11:0] >= OFF_PRIO_LO && req_addr[11:0] <= OFF_PRIO_HI)
        |=> ((rsp_rdata & LOW32) == 32'd0));

    assert_rsp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_exec_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_prio >= -10'sd1) && (exec_prio <= 10'sd256));

endmodule

// File: tb/tb_intc_gate_top.sv
// Bench: vector table walk of the register map, then directed tests for
// reset, execution priority and the active bank.
module tb_intc_gate_top;
    localparam int NUM_EXT   = 32;
    localparam int PRIO_BITS = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0]        req_addr = '0, req_wdata = '0;
    logic [3:0]         req_strb = '0;
    logic               req_ready, rsp_valid, rsp_err;
    logic [31:0]        rsp_rdata;
    logic [NUM_EXT-1:0] act_i = '0, en_o, pend_o;
    logic               faultmask_i = 1'b0, primask_i = 1'b0;
    logic [7:0]         basepri_i = '0;
    logic signed [9:0]  exec_prio;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intc_gate_top #(.NUM_EXT(NUM_EXT), .PRIO_BITS(PRIO_BITS)) dut (.*);

    typedef struct packed {
        logic        wr;
        logic        usr;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [3:0]  st;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 12'h100, 32'h0000_00F1, 4'hF, 32'h0,         1'b0, 4'd4},
        '{1'b0, 1'b0, 12'h180, 32'h0,         4'hF, 32'h0000_00F1, 1'b0, 4'd4},
        '{1'b1, 1'b0, 12'h180, 32'h0000_0011, 4'hF, 32'h0,         1'b0, 4'd4},
        '{1'b0, 1'b0, 12'h100, 32'h0,         4'hF, 32'h0000_00E0, 1'b0, 4'd4},
        '{1'b1, 1'b1, 12'h100, 32'hFFFF_FFFF, 4'hF, 32'h0,         1'b1, 4'd1},
        '{1'b0, 1'b0, 12'h100, 32'h0,         4'hF, 32'h0000_00E0, 1'b0, 4'd1},
        '{1'b0, 1'b1, 12'h100, 32'h0,         4'hF, 32'h0,         1'b1, 4'd1},
        '{1'b1, 1'b1, 12'hF00, 32'h5,         4'hF, 32'h0,         1'b1, 4'd2},
        '{1'b0, 1'b0, 12'h200, 32'h0,         4'hF, 32'h0,         1'b0, 4'd2},
        '{1'b1, 1'b0, 12'hD14, 32'h2,         4'hF, 32'h0,         1'b0, 4'd2},
        '{1'b0, 1'b0, 12'hD14, 32'h0,         4'hF, 32'h2,         1'b0, 4'd2},
        '{1'b1, 1'b1, 12'hF00, 32'h5,         4'hF, 32'h0,         1'b0, 4'd2},
        '{1'b0, 1'b0, 12'h280, 32'h0,         4'hF, 32'h0000_0020, 1'b0, 4'd3},
        '{1'b1, 1'b0, 12'hF00, 32'd32,        4'hF, 32'h0,         1'b0, 4'd3},
        '{1'b1, 1'b0, 12'hF00, 32'h0000_021F, 4'hF, 32'h0,         1'b0, 4'd3},
        '{1'b0, 1'b0, 12'h200, 32'h0,         4'hF, 32'h8000_0020, 1'b0, 4'd3},
        '{1'b1, 1'b0, 12'h280, 32'h0000_0020, 4'hF, 32'h0,         1'b0, 4'd5},
        '{1'b0, 1'b0, 12'h200, 32'h0,         4'hF, 32'h8000_0000, 1'b0, 4'd5},
        '{1'b1, 1'b0, 12'h100, 32'h0000_00FF, 4'h1, 32'h0,         1'b0, 4'd9},
        '{1'b0, 1'b0, 12'h100, 32'h0,         4'hF, 32'h0000_00E0, 1'b0, 4'd9},
        '{1'b1, 1'b0, 12'h404, 32'hFFFF_FFFF, 4'h5, 32'h0,         1'b0, 4'd7},
        '{1'b0, 1'b0, 12'h404, 32'h0,         4'hF, 32'h00E0_00E0, 1'b0, 4'd7},
        '{1'b1, 1'b0, 12'h404, 32'h4060_0000, 4'hC, 32'h0,         1'b0, 4'd7},
        '{1'b0, 1'b0, 12'h404, 32'h0,         4'hF, 32'h4060_00E0, 1'b0, 4'd7},
        '{1'b1, 1'b0, 12'h300, 32'hFFFF_FFFF, 4'hF, 32'h0,         1'b0, 4'd6},
        '{1'b0, 1'b0, 12'h300, 32'h0,         4'hF, 32'h0,         1'b0, 4'd6},
        '{1'b0, 1'b0, 12'h800, 32'h0,         4'hF, 32'h0,         1'b0, 4'd10},
        '{1'b0, 1'b1, 12'hF00, 32'h0,         4'hF, 32'h0,         1'b0, 4'd3},
        '{1'b0, 1'b0, 12'h5EC, 32'h0,         4'hF, 32'h0,         1'b0, 4'd7}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic usr, input logic [11:0] a,
                          input logic [31:0] d, input logic [3:0] s,
                          output logic [31:0] rd, output logic er, output logic vl);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_user = usr;
        req_addr = {20'h0, a}; req_wdata = d; req_strb = s;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
        rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic er, vl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 reset en_o", en_o, 32'h0);
        check("R10 reset pend_o", pend_o, 32'h0);
        check("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'h0);
        check("R10 reset exec_prio", {{22{exec_prio[9]}}, exec_prio}, 32'd256);
        check("R10 ready", {31'd0, req_ready}, 32'h1);

        for (int k = 0; k < NV; k++) begin
            access(VECS[k].wr, VECS[k].usr, VECS[k].addr, VECS[k].wd, VECS[k].st, rd, er, vl);
            check($sformatf("R%0d vec%0d rdata", VECS[k].req, k), rd, VECS[k].exp);
            check($sformatf("R%0d vec%0d err", VECS[k].req, k), {31'd0, er}, {31'd0, VECS[k].err});
            if (k == 0) check("R10 rsp_valid", {31'd0, vl}, 32'h1);
        end

        // R4 / R5 output vectors after the table
        check("R4 en_o", en_o, 32'h0000_00E0);
        check("R5 pend_o", pend_o, 32'h8000_0000);

        // R6: active bank reads act_i
        act_i = 32'h0000_0090;
        access(1'b0, 1'b0, 12'h300, 32'h0, 4'hF, rd, er, vl);
        check("R6 active read", rd, 32'h0000_0090);

        // R8: execution priority ladder (irq4 = 0xE0, irq7 = 0x40)
        #1 check("R8 active min", {{22{exec_prio[9]}}, exec_prio}, 32'd64);
        act_i = 32'h0000_0010;
        #1 check("R8 single active", {{22{exec_prio[9]}}, exec_prio}, 32'd224);
        basepri_i = 8'h3F;
        #1 check("R8 basepri masked", {{22{exec_prio[9]}}, exec_prio}, 32'd32);
        primask_i = 1'b1;
        #1 check("R8 primask", {{22{exec_prio[9]}}, exec_prio}, 32'd0);
        faultmask_i = 1'b1;
        #1 check("R8 faultmask", {{22{exec_prio[9]}}, exec_prio}, 32'hFFFF_FFFF);
        faultmask_i = 1'b0; primask_i = 1'b0; basepri_i = 8'h0; act_i = '0;
        #1 check("R8 idle", {{22{exec_prio[9]}}, exec_prio}, 32'd256);

        // R1: user write to priority has no effect
        access(1'b1, 1'b1, 12'h404, 32'h0, 4'hF, rd, er, vl);
        access(1'b0, 1'b0, 12'h404, 32'h0, 4'hF, rd, er, vl);
        check("R1 prio untouched", rd, 32'h4060_00E0);

        // R2: clearing permit blocks the user trigger again
        access(1'b1, 1'b0, 12'hD14, 32'h0, 4'hF, rd, er, vl);
        access(1'b1, 1'b1, 12'hF00, 32'h1, 4'hF, rd, er, vl);
        check("R2 blocked err", {31'd0, er}, 32'h1);
        check("R2 blocked pend", pend_o, 32'h8000_0000);

        // R10: reset mid-run clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        check("R10 reset2 en_o", en_o, 32'h0);
        check("R10 reset2 pend_o", pend_o, 32'h0);
        access(1'b0, 1'b0, 12'h404, 32'h0, 4'hF, rd, er, vl);
        check("R10 reset2 prio", rd, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule